// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block collects the event pulses of a serial peripheral's data path into a sticky status register, masks them with a per-bit enable register and a single global enable bit, and drives one level-sensitive interrupt line. Six kinds of event feed the status register: transmit empty, transmit underrun, receive full, receive overrun, transmit half-empty and receive not-empty. There are also two level inputs that re-assert the receive bits for as long as the receive queue stays non-empty or full, and a byte-transferred pulse that marks both a drained transmit slot and newly received data.

Software reaches the three registers through a simple 32-bit register port. A write takes effect on a clock edge, and the read data is combinational from the address. A write to the status register is XORed into its contents, so each written 1 flips the matching bit. The usual way to acknowledge an event is therefore to write back the bits that were read as set. The interrupt line is combinational from the three registers, so it follows any register update in the same cycle that the update becomes visible.

Top module: `intr_sticky_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the status, enable and global enable registers, so every register reads 0 and `irq_o` is low in the cycle after reset.
- R2: Each event pulse sets its status bit at the next clock edge. The bit positions are: transmit empty bit 2, transmit underrun bit 3, receive full bit 4, receive overrun bit 5, transmit half-empty bit 6, receive not-empty bit 8.
- R3: While `lvl_rx_nonempty` is high, status bit 8 is set again on every edge. While `lvl_rx_full` is high, status bit 4 is set again on every edge.
- R4: A `ev_byte_done` pulse sets both status bit 2 and status bit 8.
- R5: A write to byte offset 0x20 XORs the written data into the status register. Each 1 flips the matching implemented bit, and each 0 leaves it unchanged. A 1 written to a clear bit sets that bit.
- R6: If an event and a status write hit the same bit in the same cycle, the event wins and the bit ends at 1.
- R7: The enable register at offset 0x28 stores the written value of the implemented bits (2, 3, 4, 5, 6, 8). The global enable register at offset 0x1C stores only bit 31. Both read back what was stored.
- R8: `irq_o` is high exactly when global enable bit 31 is set and at least one bit of (status AND enable) is set.
- R9: A status bit stays set until software flips it; without an event or a status write, the status register holds its value.
- R10: Unimplemented register bits read 0. Reads of any other offset return 0, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| ev_tx_empty | input | 1 | Transmit empty event pulse |
| ev_tx_underrun | input | 1 | Transmit underrun event pulse |
| ev_rx_full | input | 1 | Receive full event pulse |
| ev_rx_overrun | input | 1 | Receive overrun event pulse |
| ev_tx_half | input | 1 | Transmit half-empty event pulse |
| ev_rx_nonempty | input | 1 | Receive not-empty event pulse |
| lvl_rx_nonempty | input | 1 | Receive queue currently non-empty (level) |
| lvl_rx_full | input | 1 | Receive queue currently full (level) |
| ev_byte_done | input | 1 | One byte transferred |
| irq_o | output | 1 | Level interrupt output |

## Verification
Several rules are checked on every cycle: that events set their bits, that set wins over a toggle, that the status register is sticky and that a write toggles it, that the output is gated by the global enable and needs an enabled pending bit, and that unimplemented bits stay 0. The scenarios show what a property cannot see on its own. These are the full register readback through the port, that writes to unmapped offsets have no effect, the mapping of every named event to its bit position, and the complete output equation under a long random mix of writes and events compared against a bench model.

// File: rtl/intr_pkg.sv
// Package: register offsets, status bit positions and masks shared by the
// interrupt aggregator and its checker. Assumes byte offsets fit in 8 bits.
package intr_pkg;
    localparam int unsigned OFS_W    = 8;
    localparam logic [OFS_W-1:0] OFS_GIE  = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_STAT = 8'h20;
    localparam logic [OFS_W-1:0] OFS_EN   = 8'h28;

    localparam int unsigned B_TXE  = 2;
    localparam int unsigned B_TXU  = 3;
    localparam int unsigned B_RXF  = 4;
    localparam int unsigned B_RXO  = 5;
    localparam int unsigned B_TXH  = 6;
    localparam int unsigned B_RXNE = 8;
    localparam int unsigned B_GIE  = 31;

    localparam logic [31:0] STAT_MASK = (32'd1 << B_TXE) | (32'd1 << B_TXU) |
                                        (32'd1 << B_RXF) | (32'd1 << B_RXO) |
                                        (32'd1 << B_TXH) | (32'd1 << B_RXNE);
    localparam logic [31:0] GIE_MASK  = 32'd1 << B_GIE;
endpackage

// File: rtl/intr_evt_map.sv
// Module: maps the named data-path events and levels onto a set vector laid
// out like the status register. Pure combinational; assumes DATA_W >= 9.
module intr_evt_map
    import intr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              ev_tx_empty,
    input  logic              ev_tx_underrun,
    input  logic              ev_rx_full,
    input  logic              ev_rx_overrun,
    input  logic              ev_tx_half,
    input  logic              ev_rx_nonempty,
    input  logic              lvl_rx_nonempty,
    input  logic              lvl_rx_full,
    input  logic              ev_byte_done,
    output logic [DATA_W-1:0] set_vec
);
    // Build the per-bit set request from pulses and levels.
    always_comb begin
        set_vec         = '0;
        set_vec[B_TXE]  = ev_tx_empty | ev_byte_done;
        set_vec[B_TXU]  = ev_tx_underrun;
        set_vec[B_RXF]  = ev_rx_full | lvl_rx_full;
        set_vec[B_RXO]  = ev_rx_overrun;
        set_vec[B_TXH]  = ev_tx_half;
        set_vec[B_RXNE] = ev_rx_nonempty | lvl_rx_nonempty | ev_byte_done;
    end
endmodule

// File: rtl/intr_regs.sv
// Module: status, enable and global enable registers with the register port.
// Status writes toggle; hardware set requests win over a toggle. Read data is
// combinational from the address. Assumes ADDR_W >= 8 and DATA_W == 32.
module intr_regs
    import intr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] enable_q,
    output logic [DATA_W-1:0] gie_q,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] S_MASK = DATA_W'(STAT_MASK);
    localparam logic [DATA_W-1:0] G_MASK = DATA_W'(GIE_MASK);

    logic hit_gie, hit_stat, hit_en;
    logic [DATA_W-1:0] toggle;

    // Decode which register the current access targets.
    always_comb begin
        hit_gie  = (addr == ADDR_W'(OFS_GIE));
        hit_stat = (addr == ADDR_W'(OFS_STAT));
        hit_en   = (addr == ADDR_W'(OFS_EN));
        toggle   = (wr_en && hit_stat) ? wdata : '0;
    end

    // Status: toggle by software, then OR in hardware events (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((status_q ^ toggle) | set_vec) & S_MASK;
    end

    // Enable and global enable: plain storage of implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            gie_q    <= '0;
        end else if (wr_en) begin
            if (hit_en)  enable_q <= wdata & S_MASK;
            if (hit_gie) gie_q    <= wdata & G_MASK;
        end
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (hit_gie)  rdata = gie_q;
        if (hit_stat) rdata = status_q;
        if (hit_en)   rdata = enable_q;
    end
endmodule

// File: rtl/intr_out.sv
// Module: forms the level interrupt from the pending, enabled bits and the
// global enable. Combinational; assumes the registers are already masked.
module intr_out
    import intr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] enable,
    input  logic [DATA_W-1:0] gie,
    output logic              irq
);
    // Any enabled pending bit, gated by the global enable.
    always_comb irq = gie[B_GIE] && (|(status & enable));
endmodule

// File: rtl/intr_sticky_ctrl.sv
// Module: top of the sticky interrupt aggregator. Connects the event map,
// the register file and the output stage. Assumes a single clock domain and
// event inputs that are synchronous to clk.
module intr_sticky_ctrl #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_tx_empty,
    input  logic              ev_tx_underrun,
    input  logic              ev_rx_full,
    input  logic              ev_rx_overrun,
    input  logic              ev_tx_half,
    input  logic              ev_rx_nonempty,
    input  logic              lvl_rx_nonempty,
    input  logic              lvl_rx_full,
    input  logic              ev_byte_done,
    output logic              irq_o
);
    logic [DATA_W-1:0] set_vec, status_q, enable_q, gie_q;

    intr_evt_map #(.DATA_W(DATA_W)) i_map (
        .ev_tx_empty(ev_tx_empty), .ev_tx_underrun(ev_tx_underrun),
        .ev_rx_full(ev_rx_full), .ev_rx_overrun(ev_rx_overrun),
        .ev_tx_half(ev_tx_half), .ev_rx_nonempty(ev_rx_nonempty),
        .lvl_rx_nonempty(lvl_rx_nonempty), .lvl_rx_full(lvl_rx_full),
        .ev_byte_done(ev_byte_done), .set_vec(set_vec)
    );

    intr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .set_vec(set_vec), .status_q(status_q),
        .enable_q(enable_q), .gie_q(gie_q), .rdata(reg_rdata)
    );

    intr_out #(.DATA_W(DATA_W)) i_out (
        .status(status_q), .enable(enable_q), .gie(gie_q), .irq(irq_o)
    );
endmodule

// File: rtl/intr_sticky_chk.sv
// Module: assertion checker bound to intr_sticky_ctrl. Observes the ports and
// the three registers; drives nothing.
module intr_sticky_chk
    import intr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              e_txe,
    input logic              e_txu,
    input logic              e_rxf,
    input logic              e_rxo,
    input logic              e_txh,
    input logic              e_rxne,
    input logic              l_rxne,
    input logic              l_rxf,
    input logic              e_byte,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] enable,
    input logic [DATA_W-1:0] gie,
    input logic              irq
);
    localparam logic [DATA_W-1:0] S_MASK = DATA_W'(STAT_MASK);
    localparam logic [DATA_W-1:0] G_MASK = DATA_W'(GIE_MASK);

    logic any_set, stat_wr;
    always_comb begin
        any_set = e_txe | e_txu | e_rxf | e_rxo | e_txh | e_rxne | l_rxne | l_rxf | e_byte;
        stat_wr = wr_en && (addr == ADDR_W'(OFS_STAT));
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (status == '0 && enable == '0 && gie == '0 && !irq)); // R1
    AST_TXE_SETS: assert property (@(posedge clk) disable iff (!rst_n) (e_txe || e_byte) |=> status[B_TXE]); // R2
    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n) e_rxo |=> status[B_RXO]); // R2
    AST_LVL_RXNE: assert property (@(posedge clk) disable iff (!rst_n) l_rxne |=> status[B_RXNE]); // R3
    AST_LVL_RXF: assert property (@(posedge clk) disable iff (!rst_n) l_rxf |=> status[B_RXF]); // R3
    AST_BYTE_RXNE: assert property (@(posedge clk) disable iff (!rst_n) e_byte |=> status[B_RXNE]); // R4
    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) (stat_wr && !any_set) |=> status == (($past(status) ^ $past(wdata)) & S_MASK)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (stat_wr && wdata[B_TXU] && e_txu) |=> status[B_TXU]); // R6
    AST_GIE_ONLY31: assert property (@(posedge clk) disable iff (!rst_n) (gie & ~G_MASK) == '0); // R7
    AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n) !gie[B_GIE] |-> !irq); // R8
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (|(status & enable))); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!stat_wr && !any_set) |=> $stable(status)); // R9
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ((status | enable) & ~S_MASK) == '0); // R10
endmodule

bind intr_sticky_ctrl intr_sticky_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .e_txe(ev_tx_empty), .e_txu(ev_tx_underrun), .e_rxf(ev_rx_full),
    .e_rxo(ev_rx_overrun), .e_txh(ev_tx_half), .e_rxne(ev_rx_nonempty),
    .l_rxne(lvl_rx_nonempty), .l_rxf(lvl_rx_full), .e_byte(ev_byte_done),
    .status(status_q), .enable(enable_q), .gie(gie_q), .irq(irq_o)
);

// File: tb/test_intr_sticky_ctrl.sv
// Bench: directed corner cases plus seeded random traffic, compared with a
// register model kept in the bench.
module test_intr_sticky_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_GIE = 8'h1C, A_ST = 8'h20, A_EN = 8'h28;
    localparam logic [31:0] MASK = 32'h0000_017C;

    logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, irq;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0, rdata;
    logic [8:0]  ev = '0; // 0 txe,1 txu,2 rxf,3 rxo,4 txh,5 rxne,6 lvl_ne,7 lvl_full,8 byte
    logic [31:0] m_st = '0, m_en = '0, m_g = '0;
    int n_tot = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_sticky_ctrl i_intr_sticky_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata),
        .ev_tx_empty(ev[0]), .ev_tx_underrun(ev[1]), .ev_rx_full(ev[2]),
        .ev_rx_overrun(ev[3]), .ev_tx_half(ev[4]), .ev_rx_nonempty(ev[5]),
        .lvl_rx_nonempty(ev[6]), .lvl_rx_full(ev[7]), .ev_byte_done(ev[8]),
        .irq_o(irq)
    );

    function automatic logic [31:0] set_of(input logic [8:0] e);
        logic [31:0] s = '0;
        s[2] = e[0] | e[8];
        s[3] = e[1];
        s[4] = e[2] | e[7];
        s[5] = e[3];
        s[6] = e[4];
        s[8] = e[5] | e[6] | e[8];
        return s;
    endfunction

    function automatic logic irq_of(input logic [31:0] st, en, g);
        return g[31] && (|(st & en));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, exp);
        n_tot++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, then idle inputs.
    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [8:0] e);
        @(negedge clk);
        wr = w; addr = a; wdata = d; ev = e;
        @(posedge clk);
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_g = '0;
        end else begin
            m_st = ((m_st ^ ((w && a == A_ST) ? d : 32'h0)) | set_of(e)) & MASK;
            if (w && a == A_EN)  m_en = d & MASK;
            if (w && a == A_GIE) m_g  = d & 32'h8000_0000;
        end
        #1;
        wr = 1'b0; ev = '0;
    endtask

    // Read every register through the port and compare with the model.
    task automatic check_all(input string req);
        addr = A_ST;  #1 chk({req, " status"}, rdata, m_st);
        addr = A_EN;  #1 chk({req, " enable"}, rdata, m_en);
        addr = A_GIE; #1 chk({req, " gie"},    rdata, m_g);
        chk({req, " irq"}, {31'h0, irq}, {31'h0, irq_of(m_st, m_en, m_g)});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tot++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) cyc(1'b0, 8'h00, '0, '0);
        check_all("R1");
        @(negedge clk) rst_n = 1'b1;

        // R2: each event alone sets its own bit; clear by toggling back (R5)
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 8'h00, '0, 9'(1 << i));
            check_all("R2");
            cyc(1'b1, A_ST, m_st, '0);
            check_all("R5 clear");
        end
        // R3: level inputs re-set after a clear
        cyc(1'b0, 8'h00, '0, 9'b0_1100_0000);
        cyc(1'b1, A_ST, 32'h0000_0110, 9'b0_1100_0000);
        check_all("R3");
        cyc(1'b1, A_ST, 32'h0000_0110, '0);
        check_all("R3 release");
        // R4: byte transfer sets bits 2 and 8
        cyc(1'b0, 8'h00, '0, 9'b1_0000_0000);
        check_all("R4");
        chk("R4 bits", m_st, 32'h0000_0104);
        // R5: write 1 to a clear bit sets it, 0 keeps
        cyc(1'b1, A_ST, 32'h0000_0048, '0);
        check_all("R5 toggle");
        // R6: toggle and event on bit 3 in the same cycle -> stays 1
        cyc(1'b1, A_ST, 32'h0000_0008, 9'b0_0000_0010);
        check_all("R6");
        chk("R6 bit3", {31'h0, m_st[3]}, 32'h1);
        // R7/R8: enable without gie -> no irq, then gie gates it on
        cyc(1'b1, A_EN, 32'hFFFF_FFFF, '0);
        check_all("R7 enable");
        chk("R8 no gie", {31'h0, irq}, 32'h0);
        cyc(1'b1, A_GIE, 32'hFFFF_FFFF, '0);
        check_all("R7 gie");
        chk("R8 gie on", {31'h0, irq}, 32'h1);
        // R9: idle cycles keep status
        repeat (4) cyc(1'b0, 8'h00, '0, '0);
        check_all("R9");
        // R10: writes to other offsets do nothing; reads return 0
        cyc(1'b1, 8'h24, 32'hFFFF_FFFF, '0);
        cyc(1'b1, 8'h00, 32'hFFFF_FFFF, '0);
        check_all("R10 write");
        addr = 8'h24; #1 chk("R10 read", rdata, 32'h0);
        // Random traffic
        for (int k = 0; k < 600; k++) begin
            logic [2:0] sel = 3'($urandom_range(0, 5));
            logic [7:0] a;
            logic [8:0] e = '0;
            case (sel)
                3'd0: a = A_GIE;
                3'd1, 3'd2: a = A_ST;
                3'd3: a = A_EN;
                3'd4: a = 8'h2C;
                default: a = 8'h40;
            endcase
            for (int b = 0; b < 9; b++) e[b] = ($urandom_range(0, 5) == 0);
            cyc($urandom_range(0, 1) == 1, a, $urandom, e);
            check_all("R8 random");
        end
        // R1: reset mid-run clears everything
        @(negedge clk) rst_n = 1'b0;
        cyc(1'b0, 8'h00, '0, '0);
        check_all("R1 mid");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end
endmodule